// File: doc/BRIEF.md
# Shared GPIO Pin State Register

This block holds the software side of 22 general-purpose pins that are each shared with a dedicated peripheral. A bus write loads an output latch. The latch value reaches a pad only when that pin's direction bit selects output and its owning peripheral is disabled. In every other case the peripheral's own output value and output enable pass straight through to the pad. When the direction bit selects input and the peripheral is off, the pin is not driven.

A bus read never returns the latch. It returns a separate capture register. That register holds the pad levels after a two-stage synchronizer, and it loads only on a slow periodic sample pulse. This pulse comes from a divider of the system clock. Readback therefore shows the real level on every pin, whoever drives it. A value that was just written appears in readback only after it has crossed the synchronizer and a later sample pulse has captured it. The output latch has no reset, so a value written before a reset keeps driving after the reset.

The sample divider is a two-state machine. In `TK_COUNT` it counts system clocks. The transition COUNT→SAMPLE is taken when the count reaches its last value, or at once when the ratio is 0 or 1. `TK_SAMPLE` raises the pulse for one cycle. The transition SAMPLE→COUNT clears the count. The transition SAMPLE→SAMPLE is taken when the ratio is 0 or 1, which makes the pulse continuous. Reset enters `TK_COUNT` with the count at zero.

Top module: `gpio_pinstate`

## Requirements
- R1: Bits 31:22 of `rd_data` always read as zero.
- R2: Pin i is software-owned when `dir_out[i]`=1 and `periph_en[i]`=0. For such a pin, `pad_oe[i]`=1 and `pad_out[i]` equals bit i of the last full-word write: 0 drives low and 1 drives high.
- R3: When `periph_en[i]`=1, `pad_out[i]`=`periph_do[i]` and `pad_oe[i]`=`periph_oe[i]`, whatever was written.
- R4: When `dir_out[i]`=0 and `periph_en[i]`=0, `pad_oe[i]`=0, and a written bit for pin i has no effect on the pad.
- R5: `rd_data[21:0]` shows the synchronized pad levels on every pin, including peripheral-driven pins, and changes only in the cycle after a sample pulse.
- R6: With ratio r=`div_ratio` (0 and 1 both mean 1), the sample pulse occurs on every r-th cycle. The first pulse after reset falls in cycle r-1, counting the first cycle after reset as cycle 0.
- R7: A pad level stable from clock edge e onward appears in `rd_data` at edge e+3 at the earliest and at edge e+r+2 at the latest.
- R8: The output latch is not cleared by reset. A value written before a reset still drives software-owned pins after the reset.
- R9: The latch loads only on a cycle with `wr_en`=1. Bits 31:22 of `wr_data` are ignored.
- R10: Reset clears the capture register, so `rd_data` reads zero until the first sample that sees a high pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle full-word write strobe |
| wr_data | input | 32 | Write data; bits 21:0 are pin values |
| rd_data | output | 32 | Synchronized pin levels in bits 21:0, zero above |
| div_ratio | input | 16 | Sample divider ratio in system clocks |
| dir_out | input | 22 | Per-pin direction, 1 = output |
| periph_en | input | 22 | Per-pin owning peripheral enabled |
| periph_oe | input | 22 | Peripheral output enable |
| periph_do | input | 22 | Peripheral output value |
| pad_in | input | 22 | Pad input levels |
| pad_out | output | 22 | Pad output values |
| pad_oe | output | 22 | Pad output enables |

## Verification
Some rules are checked on every cycle by the assertions. These are the zero reserved bits and the peripheral pass-through. They also cover the undriven state of idle input pins and the capture register holding between sample pulses. The same goes for loading from the second synchronizer stage, latch hold without a strobe, and the single-cycle sample pulse. Other behaviour needs the bench's scenarios with a pad loopback:
- the end-to-end readback latency window,
- the survival of the latch across a reset,
- the exact pulse phase after reset for several ratios,
- the visible effect of writes on input pins and on peripheral-owned pins.

// File: rtl/gpst_pkg.sv
package gpst_pkg;
    localparam int unsigned PIN_COUNT  = 22;
    localparam int unsigned WORD_WIDTH = 32;
    localparam int unsigned DIV_WIDTH  = 16;

    typedef enum logic {
        TK_COUNT  = 1'b0,
        TK_SAMPLE = 1'b1
    } tick_state_e;
endpackage

// File: rtl/gpst_tick.sv
module gpst_tick #(
    parameter int unsigned DIV_W = gpst_pkg::DIV_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick
);
    import gpst_pkg::*;

    tick_state_e      st_q, st_d;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last_cnt;
    logic             ratio_one;

    assign ratio_one = (ratio <= DIV_W'(1));
    assign last_cnt  = ratio - DIV_W'(2);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TK_COUNT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= (st_q == TK_COUNT && st_d == TK_COUNT) ? cnt_q + DIV_W'(1) : '0;
        end
    end

    // next state and outputs
    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        unique case (st_q)
            TK_COUNT: begin
                tick = ratio_one;
                if (ratio_one || cnt_q >= last_cnt) st_d = TK_SAMPLE;
            end
            TK_SAMPLE: begin
                tick = 1'b1;
                st_d = ratio_one ? TK_SAMPLE : TK_COUNT;
            end
            default: begin
                st_d = TK_COUNT;
                tick = 1'b0;
            end
        endcase
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ratio_one && $stable(ratio)) |=> !tick); // R6
endmodule

// File: rtl/gpst_sync.sv
module gpst_sync #(
    parameter int unsigned W = gpst_pkg::PIN_COUNT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] level
);
    logic [W-1:0] meta_q, stab_q, level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q  <= '0;
            stab_q  <= '0;
            level_q <= '0;
        end else begin
            meta_q <= pad_in;
            stab_q <= meta_q;
            if (tick) level_q <= stab_q;
        end
    end

    assign level = level_q;

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(level_q)); // R5
    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (level_q == $past(stab_q))); // R7
endmodule

// File: rtl/gpst_out_latch.sv
module gpst_out_latch #(
    parameter int unsigned W = gpst_pkg::PIN_COUNT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_bits,
    output logic [W-1:0] latch
);
    logic [W-1:0] latch_q;

    // deliberately without reset
    always_ff @(posedge clk) begin
        if (wr_en) latch_q <= wr_bits;
    end

    assign latch = latch_q;

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(latch_q)); // R9
    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (latch_q == $past(wr_bits))); // R2
endmodule

// File: rtl/gpst_pin_mux.sv
module gpst_pin_mux #(
    parameter int unsigned W = gpst_pkg::PIN_COUNT
) (
    input  logic [W-1:0] dir_out,
    input  logic [W-1:0] periph_en,
    input  logic [W-1:0] periph_oe,
    input  logic [W-1:0] periph_do,
    input  logic [W-1:0] latch,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic sw_own;
        assign sw_own     = dir_out[i] & ~periph_en[i];
        assign pad_out[i] = sw_own ? latch[i] : periph_do[i];
        assign pad_oe[i]  = periph_en[i] ? periph_oe[i] : dir_out[i];
    end
endmodule

// File: rtl/gpio_pinstate.sv
module gpio_pinstate #(
    parameter int unsigned NUM_PINS = gpst_pkg::PIN_COUNT,
    parameter int unsigned WORD_W   = gpst_pkg::WORD_WIDTH,
    parameter int unsigned DIV_W    = gpst_pkg::DIV_WIDTH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [WORD_W-1:0]   rd_data,
    input  logic [DIV_W-1:0]    div_ratio,
    input  logic [NUM_PINS-1:0] dir_out,
    input  logic [NUM_PINS-1:0] periph_en,
    input  logic [NUM_PINS-1:0] periph_oe,
    input  logic [NUM_PINS-1:0] periph_do,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);
    localparam int unsigned RSVD_W = WORD_W - NUM_PINS;

    logic                sample_tick;
    logic [NUM_PINS-1:0] latch_bits;
    logic [NUM_PINS-1:0] level_bits;

    gpst_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .ratio (div_ratio),
        .tick  (sample_tick)
    );

    gpst_sync #(.W(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (sample_tick),
        .pad_in (pad_in),
        .level  (level_bits)
    );

    gpst_out_latch #(.W(NUM_PINS)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bits (wr_data[NUM_PINS-1:0]),
        .latch   (latch_bits)
    );

    gpst_pin_mux #(.W(NUM_PINS)) u_mux (
        .dir_out   (dir_out),
        .periph_en (periph_en),
        .periph_oe (periph_oe),
        .periph_do (periph_do),
        .latch     (latch_bits),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    assign rd_data = {{RSVD_W{1'b0}}, level_bits};

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[WORD_W-1:NUM_PINS] == '0); // R1
    AST_RSVD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && |wr_data[WORD_W-1:NUM_PINS]) |=> (rd_data[WORD_W-1:NUM_PINS] == '0)); // R9
    AST_PERIPH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & periph_en) == (periph_do & periph_en)) &&
        ((pad_oe & periph_en) == (periph_oe & periph_en))); // R3
    AST_IDLE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir_out & ~periph_en) == '0); // R4
endmodule

// File: tb/gpio_pinstate_tb_top.sv
module gpio_pinstate_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [15:0]   div_ratio = 16'd4;
    logic [NP-1:0] dir_out = '0, periph_en = '0, periph_oe = '0, periph_do = '0;
    logic [NP-1:0] ext_in = '0, pad_in, pad_out, pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_in);

    gpio_pinstate dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .div_ratio(div_ratio), .dir_out(dir_out), .periph_en(periph_en),
        .periph_oe(periph_oe), .periph_do(periph_do), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: snapshots at negedge, update at posedge
    logic [NP-1:0] hist[$];
    logic [NP-1:0] m_rd = '0, m_latch = '0;
    bit            m_latch_ok = 1'b0;
    int            m_cnt = 0;
    logic [NP-1:0] s_pad;
    logic          s_wr;
    logic [NP-1:0] s_wbits;

    function automatic int ratio_eff();
        return (div_ratio < 2) ? 1 : int'(div_ratio);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist = '{NP'(0), NP'(0)};
            m_rd = '0;
            m_cnt = 0;
        end else begin
            if (m_cnt == ratio_eff() - 1) begin
                m_rd = hist[0];
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
            hist.push_back(s_pad);
            void'(hist.pop_front());
        end
        if (rst_n && s_wr) begin
            m_latch = s_wbits;
            m_latch_ok = 1'b1;
        end
    end

    always @(negedge clk) begin
        logic [NP-1:0] sw, msk, exp_oe, exp_out;
        s_pad   = pad_in;
        s_wr    = wr_en;
        s_wbits = wr_data[NP-1:0];
        if (rst_n && !done) begin
            sw      = dir_out & ~periph_en;
            exp_oe  = (periph_en & periph_oe) | (~periph_en & dir_out);
            exp_out = (sw & m_latch) | (~sw & periph_do);
            msk     = periph_en | (m_latch_ok ? sw : '0);
            chk(rd_data == {10'b0, m_rd}, "R5 R6 R7 per-cycle readback", rd_data, {10'b0, m_rd});
            chk(pad_oe == exp_oe, "R2 R3 R4 per-cycle pad_oe", 32'(pad_oe), 32'(exp_oe));
            chk((pad_out & msk) == (exp_out & msk), "R2 R3 per-cycle pad_out",
                32'(pad_out & msk), 32'(exp_out & msk));
        end
    end

    task automatic tick_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_write(input logic [31:0] v);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = v;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_data = 32'hFFFF_FFFF;
    endtask

    task automatic do_reset(input logic [15:0] r);
        @(posedge clk); #1;
        rst_n = 1'b0; div_ratio = r;
        tick_cycles(3);
        rst_n = 1'b1;
    endtask

    // change an input-pin level right after an edge and count edges until readback shows it
    task automatic latency(input logic [NP-1:0] newv, input string tag);
        int n = 0;
        int r = ratio_eff();
        @(posedge clk); #1;
        ext_in = newv;
        while (n < 60) begin
            @(posedge clk); n++;
            @(negedge clk); #1;
            if (rd_data[NP-1:0] == newv) break;
        end
        chk(n >= 3 && n <= r + 2, tag, 32'(n), 32'(r + 2));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data == 0, "R10 reset readback", rd_data, 0);
        // full-word write with reserved bits set; all pins software outputs
        do_write(32'hFFEA_5A5A);
        dir_out = '1;
        tick_cycles(10);
        chk(pad_out == 22'h2A5A5A, "R2 written levels drive pads", 32'(pad_out), 32'h2A5A5A);
        chk(pad_oe == '1, "R2 software outputs enabled", 32'(pad_oe), 32'h3FFFFF);
        chk(rd_data == 32'h002A5A5A, "R1 R5 loopback readback", rd_data, 32'h002A5A5A);
        // strobe low: no load
        wr_data = 32'h0000_1234; tick_cycles(3);
        chk(pad_out == 22'h2A5A5A, "R9 no write without strobe", 32'(pad_out), 32'h2A5A5A);
        // peripherals own the low byte
        periph_en = 22'h0000FF; periph_oe = 22'h00000F; periph_do = 22'h0000C3;
        do_write(32'h0000_0000);
        tick_cycles(10);
        chk(pad_out[7:0] == 8'hC3 && pad_oe[7:0] == 8'h0F, "R3 peripheral pass-through",
            {pad_oe[7:0], pad_out[7:0]}, 32'h0FC3);
        chk(rd_data[3:0] == 4'h3, "R5 peripheral-driven level readback", 32'(rd_data[3:0]), 3);
        // input pins in upper half
        periph_en = '0; dir_out = 22'h0003FF; ext_in = 22'h155000;
        do_write(32'h003F_FC00);
        tick_cycles(10);
        chk(pad_oe[21:10] == '0, "R4 input pins undriven", 32'(pad_oe), 32'h3FF);
        chk(rd_data[21:10] == 12'h554, "R4 write no effect on input pins", 32'(rd_data[21:10]), 32'h554);
        latency(22'h2AA000 | (rd_data[NP-1:0] & 22'h3FF), "R7 latency ratio 4");
        // reset keeps latch, clears readback
        do_write(32'h0000_0155);
        tick_cycles(2);
        do_reset(16'd7);
        chk(rd_data == 0, "R10 readback cleared by reset", rd_data, 0);
        chk(pad_out[9:0] == 10'h155, "R8 latch survives reset", 32'(pad_out[9:0]), 32'h155);
        tick_cycles(30);
        latency(22'h155000 | (rd_data[NP-1:0] & 22'h3FF), "R6 R7 latency ratio 7");
        // ratio 0 behaves as 1
        do_reset(16'd0);
        tick_cycles(5);
        latency(22'h0AA000 | (rd_data[NP-1:0] & 22'h3FF), "R6 ratio zero as one");
        do_reset(16'd2);
        tick_cycles(5);
        latency(22'h3FF000 | (rd_data[NP-1:0] & 22'h3FF), "R6 R7 latency ratio 2");
        tick_cycles(4);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule